// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block sits on a 32-bit host register bus and gives software a way into a configuration space without a direct mapping. Software first writes a target address (enable flag, bus, device, function, register dword) into an address register, then reads or writes a data window register. Each data-window access becomes one configuration read or write at the address held in the address register. Sub-word writes choose their byte lanes from the low two address bits of the data-window access. A read of the data window always returns the whole dword, and the requester picks out the byte or halfword it wants.

The block also holds a control register that enables I/O decoding, memory decoding and bus mastering, an I/O window register (base in the upper bits, size code below it), and a small configuration space of its own, answered at bus 0, device 0, function 0. The block can therefore be tested on its own. Any other target behaves like a master abort: it reads as all ones, drops writes and sets a sticky flag.

Top module: `cfg_access_port`

## Requirements
- R1: After reset, ready_o, mabort_o and cmd_o are 0, and the address, control and I/O window registers all read 0.
- R2: The address register is at offset 0x28. Bit 31 is the enable, bits 23:16 the bus, 15:11 the device, 10:8 the function and 7:2 the register dword. Bits 30:24 and 1:0 always read 0.
- R3: When enabled and aimed at bus 0/device 0/function 0, a word write (size 2) to offset 0x2C writes all four bytes of the addressed local dword, and a read returns the whole dword.
- R4: A byte write (size 0) at offset 0x2C+k changes only byte lane k (data bits 8k+7:8k) of the addressed dword.
- R5: A halfword write (size 1) at offset 0x2C or 0x2E changes only lanes 0-1 or lanes 2-3 respectively.
- R6: With address bit 31 clear, a data-window read returns 0xFFFFFFFF, a data-window write changes nothing, and the master-abort flag is not set.
- R7: An enabled data-window access to any bus, device or function other than 0/0/0 reads 0xFFFFFFFF, drops its write and sets mabort_o. The flag stays set until a write to offset 0x08 puts a 1 in data bit 31 (byte lane 3 enabled).
- R8: The control register at offset 0x08 keeps bits 2:0 (bit 0 I/O, bit 1 memory, bit 2 bus master), drives them on cmd_o, and reads back with the master-abort flag in bit 31 and 0 in all other bits.
- R9: The I/O window register at offset 0x00 keeps bits 31:20 (base) and 19:16 (size code); bits 15:0 read 0.
- R10: ready_o is high in exactly the cycle after each request, and rdata_o is valid in that cycle.
- R11: Local dword 0 is a read-only identity value (default 0x1A2B3C4D). Local dwords at or beyond the parameterised depth (default 16) read 0 and ignore writes.
- R12: Offsets with no register read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset into the register space |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| wdata_i | input | 32 | Write data, lane aligned to the address |
| ready_o | output | 1 | Response strobe, one cycle after a request |
| rdata_o | output | 32 | Read data, valid with ready_o |
| cmd_o | output | 3 | Master enable, memory enable, I/O enable |
| mabort_o | output | 1 | Sticky master-abort flag |

## Verification
The assertions assume that a request is a single-cycle pulse, that size_i is never 3, and that halfword accesses are halfword aligned. The bench issues each access as a one-cycle pulse followed by an idle cycle, and uses only legal sizes with aligned halfword offsets. With those inputs, each data-window outcome (disabled, local, aborted) has only one correct result. The bench's reference model can therefore give the exact dword expected for every read.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam logic [5:0] SEL_IOWIN = 6'h00;
  localparam logic [5:0] SEL_CTRL  = 6'h02;
  localparam logic [5:0] SEL_ADDR  = 6'h0A;
  localparam logic [5:0] SEL_DATA  = 6'h0B;

  localparam logic [31:0] ADDR_KEEP  = 32'h80FF_FFFC;
  localparam logic [31:0] IOWIN_KEEP = 32'hFFFF_0000;

  function automatic logic [31:0] merge_be(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = be[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cfg_lane_gen.sv
module cfg_lane_gen
  import cfg_port_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic [1:0] off_i,
  output logic [3:0] be_o
);
  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: be_o = 4'b0001 << off_i;
      SZ_HALF: be_o = off_i[1] ? 4'b1100 : 4'b0011;
      SZ_WORD: be_o = 4'b1111;
      default: be_o = 4'b0000;
    endcase
  end
endmodule

// File: rtl/cfg_target_decode.sv
module cfg_target_decode (
  input  logic [31:0] cfg_addr_i,
  output logic        en_o,
  output logic        local_o,
  output logic [5:0]  idx_o
);
  // local target: bus 0, device 0, function 0
  assign en_o    = cfg_addr_i[31];
  assign local_o = (cfg_addr_i[23:8] == 16'h0000);
  assign idx_o   = cfg_addr_i[7:2];
endmodule

// File: rtl/cfg_local_space.sv
module cfg_local_space
  import cfg_port_pkg::*;
#(
  parameter int unsigned   DWORDS = 16,
  parameter logic [31:0]   ID_VAL = 32'h1A2B_3C4D
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [5:0]  idx_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int unsigned IW    = (DWORDS > 1) ? $clog2(DWORDS) : 1;
  localparam logic [6:0]  LIMIT = 7'(DWORDS);

  logic        in_range;
  logic [31:0] words [DWORDS];

  assign in_range = ({1'b0, idx_i} < LIMIT);

  for (genvar g = 0; g < DWORDS; g++) begin : g_word
    if (g == 0) begin : g_id
      assign words[g] = ID_VAL;
    end else begin : g_rw
      logic [31:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we_i && in_range && (idx_i[IW-1:0] == IW'(g)))
          q <= merge_be(q, wdata_i, be_i);
      end
      assign words[g] = q;
    end
  end

  assign rdata_o = in_range ? words[idx_i[IW-1:0]] : 32'h0;
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfg_port_pkg::*;
#(
  parameter int unsigned LOCAL_DWORDS = 16,
  parameter logic [31:0] LOCAL_ID     = 32'h1A2B_3C4D
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic        ready_o,
  output logic [31:0] rdata_o,
  output logic [2:0]  cmd_o,
  output logic        mabort_o
);
  logic [31:0] io_win_q, cfg_addr_q, rdata_q;
  logic [2:0]  ctrl_q;
  logic        mab_q, ready_q;
  logic [3:0]  be;
  logic [5:0]  sel;
  logic        tgt_en, tgt_local;
  logic [5:0]  tgt_idx;
  logic [31:0] local_rdata, rd_mux;
  logic        wr, win_acc, local_we, abort_set, abort_clr;

  assign sel = addr_i[7:2];
  assign wr  = req_i && we_i;

  cfg_lane_gen i_lanes (
    .size_i (size_i),
    .off_i  (addr_i[1:0]),
    .be_o   (be)
  );

  cfg_target_decode i_dec (
    .cfg_addr_i (cfg_addr_q),
    .en_o       (tgt_en),
    .local_o    (tgt_local),
    .idx_o      (tgt_idx)
  );

  assign win_acc   = req_i && (sel == SEL_DATA) && tgt_en;
  assign local_we  = win_acc && we_i && tgt_local;
  assign abort_set = win_acc && !tgt_local;
  assign abort_clr = wr && (sel == SEL_CTRL) && be[3] && wdata_i[31];

  cfg_local_space #(
    .DWORDS (LOCAL_DWORDS),
    .ID_VAL (LOCAL_ID)
  ) i_local (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (local_we),
    .idx_i   (tgt_idx),
    .be_i    (be),
    .wdata_i (wdata_i),
    .rdata_o (local_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_win_q   <= '0;
      cfg_addr_q <= '0;
      ctrl_q     <= '0;
    end else if (wr) begin
      unique case (sel)
        SEL_IOWIN: io_win_q   <= merge_be(io_win_q, wdata_i, be) & IOWIN_KEEP;
        SEL_ADDR:  cfg_addr_q <= merge_be(cfg_addr_q, wdata_i, be) & ADDR_KEEP;
        SEL_CTRL:  if (be[0]) ctrl_q <= wdata_i[2:0];
        default: ;
      endcase
    end
  end

  // set and clear can never coincide: they decode different offsets
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mab_q <= 1'b0;
    else if (abort_set) mab_q <= 1'b1;
    else if (abort_clr) mab_q <= 1'b0;
  end

  always_comb begin
    unique case (sel)
      SEL_IOWIN: rd_mux = io_win_q;
      SEL_CTRL:  rd_mux = {mab_q, 28'h0, ctrl_q};
      SEL_ADDR:  rd_mux = cfg_addr_q;
      SEL_DATA:  rd_mux = (tgt_en && tgt_local) ? local_rdata : 32'hFFFF_FFFF;
      default:   rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= req_i;
      if (req_i && !we_i) rdata_q <= rd_mux;
    end
  end

  assign ready_o  = ready_q;
  assign rdata_o  = rdata_q;
  assign cmd_o    = ctrl_q;
  assign mabort_o = mab_q;
endmodule

// File: rtl/cfg_access_port_chk.sv
module cfg_access_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [7:0]  addr_i,
  input logic [31:0] cfg_addr_q,
  input logic        ready_o,
  input logic [31:0] rdata_o,
  input logic [2:0]  cmd_o,
  input logic        mabort_o
);
  p_ready_follows_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o);

  p_no_spurious_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o);

  p_abort_from_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mabort_o) |-> $past(req_i && addr_i[7:2] == 6'h0B && cfg_addr_q[31]));

  p_abort_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mabort_o && !(req_i && we_i && addr_i[7:2] == 6'h02)) |=> mabort_o);

  p_cmd_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i[7:2] == 6'h02) |=> $stable(cmd_o));

  p_disabled_reads_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[7:2] == 6'h0B && !cfg_addr_q[31]) |=> rdata_o == 32'hFFFF_FFFF);
endmodule

bind cfg_access_port cfg_access_port_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .cfg_addr_q (cfg_addr_q),
  .ready_o    (ready_o),
  .rdata_o    (rdata_o),
  .cmd_o      (cmd_o),
  .mabort_o   (mabort_o)
);

// File: tb/test_cfg_access_port.sv
module test_cfg_access_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = 2'd2;
  logic [31:0] wdata = '0;
  logic        ready, mabort;
  logic [31:0] rdata;
  logic [2:0]  cmd;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_cfg [0:15];
  logic [31:0] m_io, m_addr;
  logic [2:0]  m_cmd;
  logic        m_mab;
  logic        req_seen = 1'b0;
  localparam logic [31:0] ID = 32'h1A2B_3C4D;

  always #10 clk = ~clk;

  cfg_access_port i_cfg_access_port (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we),
    .addr_i (addr), .size_i (size), .wdata_i (wdata),
    .ready_o (ready), .rdata_o (rdata), .cmd_o (cmd), .mabort_o (mabort)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R10: ready compared every clock against the one-cycle-late request
  always @(posedge clk) req_seen <= rst_n ? req : 1'b0;
  always @(negedge clk) if (rst_n && !done) check("R10 ready", {31'b0, ready}, {31'b0, req_seen});

  function automatic bit lane_on(input logic [1:0] sz, input logic [1:0] off, input int k);
    if (sz == 2'd2) return 1'b1;
    if (sz == 2'd1) return (k / 2) == int'(off[1]);
    return k == int'(off);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a[7:2])
      6'h00: return m_io;
      6'h02: return {m_mab, 28'h0, m_cmd};
      6'h0A: return m_addr;
      6'h0B: begin
        if (!m_addr[31] || m_addr[23:8] != 0) return 32'hFFFF_FFFF;
        if (m_addr[7:2] == 0) return ID;
        if (m_addr[7:2] < 16) return m_cfg[m_addr[7:2]];
        return 32'h0;
      end
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] nv;
    nv = m_read(a);
    for (int k = 0; k < 4; k++)
      if (lane_on(sz, a[1:0], k)) nv[8*k +: 8] = d[8*k +: 8];
    case (a[7:2])
      6'h00: m_io = nv & 32'hFFFF_0000;
      6'h02: begin
        if (lane_on(sz, a[1:0], 0)) m_cmd = d[2:0];
        if (lane_on(sz, a[1:0], 3) && d[31]) m_mab = 1'b0;
      end
      6'h0A: m_addr = nv & 32'h80FF_FFFC;
      6'h0B: begin
        if (m_addr[31] && m_addr[23:8] != 0) m_mab = 1'b1;
        else if (m_addr[31] && m_addr[7:2] != 0 && m_addr[7:2] < 16) m_cfg[m_addr[7:2]] = nv;
      end
      default: ;
    endcase
  endtask

  task automatic acc(input string tag, input bit w, input logic [7:0] a,
                     input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] exp;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = d;
    exp = m_read(a);
    if (!w && a[7:2] == 6'h0B && m_addr[31] && m_addr[23:8] != 0) m_mab = 1'b1;
    if (w) m_write(a, sz, d);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    if (!w) check(tag, rdata, exp);
    check({tag, " abort flag"}, {31'b0, mabort}, {31'b0, m_mab});
  endtask

  task automatic rd_lit(input string tag, input logic [7:0] a, input logic [31:0] lit);
    acc(tag, 1'b0, a, 2'd2, 32'h0);
    check({tag, " literal"}, rdata, lit);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_cfg[i] = 32'h0;
    m_io = 0; m_addr = 0; m_cmd = 0; m_mab = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ready", {31'b0, ready}, 32'h0);
    check("R1 mabort", {31'b0, mabort}, 32'h0);
    check("R1 cmd", {29'b0, cmd}, 32'h0);
    rst_n = 1'b1;
    rd_lit("R1 addr reg", 8'h28, 32'h0);
    rd_lit("R1 ctrl reg", 8'h08, 32'h0);
    rd_lit("R1 io window", 8'h00, 32'h0);

    acc("R2 addr write", 1'b1, 8'h28, 2'd2, 32'hFFFF_FFFF);
    rd_lit("R2 addr mask", 8'h28, 32'h80FF_FFFC);

    acc("R6 set disabled", 1'b1, 8'h28, 2'd2, 32'h0000_0004);
    rd_lit("R6 disabled read", 8'h2C, 32'hFFFF_FFFF);
    acc("R6 disabled write", 1'b1, 8'h2C, 2'd2, 32'h1234_5678);
    acc("R6 enable", 1'b1, 8'h28, 2'd2, 32'h8000_0004);
    rd_lit("R6 write dropped", 8'h2C, 32'h0);

    acc("R3 word write", 1'b1, 8'h2C, 2'd2, 32'hDEAD_BEEF);
    rd_lit("R3 word read", 8'h2C, 32'hDEAD_BEEF);

    acc("R4 byte lane2", 1'b1, 8'h2E, 2'd0, 32'h00AA_0000);
    rd_lit("R4 lane2 only", 8'h2C, 32'hDEAA_BEEF);
    acc("R4 byte lane0", 1'b1, 8'h2C, 2'd0, 32'h5555_5511);
    rd_lit("R4 lane0 only", 8'h2C, 32'hDEAA_BE11);

    acc("R5 half low", 1'b1, 8'h2C, 2'd1, 32'h9999_1234);
    rd_lit("R5 low lanes", 8'h2C, 32'hDEAA_1234);
    acc("R5 half high", 1'b1, 8'h2E, 2'd1, 32'h4321_7777);
    rd_lit("R5 high lanes", 8'h2C, 32'h4321_1234);

    acc("R11 point reg0", 1'b1, 8'h28, 2'd2, 32'h8000_0000);
    acc("R11 write id", 1'b1, 8'h2C, 2'd2, 32'h0);
    rd_lit("R11 id read-only", 8'h2C, ID);
    acc("R11 point reg20", 1'b1, 8'h28, 2'd2, 32'h8000_0050);
    acc("R11 write beyond", 1'b1, 8'h2C, 2'd2, 32'hCAFE_F00D);
    rd_lit("R11 beyond zero", 8'h2C, 32'h0);

    acc("R7 point bus1", 1'b1, 8'h28, 2'd2, 32'h8001_0004);
    rd_lit("R7 abort read", 8'h2C, 32'hFFFF_FFFF);
    check("R7 flag set", {31'b0, mabort}, 32'h1);
    acc("R7 point dev1", 1'b1, 8'h28, 2'd2, 32'h8000_0804);
    acc("R7 abort write", 1'b1, 8'h2C, 2'd2, 32'h0BAD_0BAD);
    acc("R7 back local", 1'b1, 8'h28, 2'd2, 32'h8000_0004);
    rd_lit("R7 write dropped", 8'h2C, 32'h4321_1234);
    check("R7 flag sticky", {31'b0, mabort}, 32'h1);
    rd_lit("R7 ctrl bit31", 8'h08, 32'h8000_0000);
    acc("R7 clear no lane3", 1'b1, 8'h08, 2'd0, 32'h0000_0000);
    check("R7 still set", {31'b0, mabort}, 32'h1);
    acc("R7 clear", 1'b1, 8'h08, 2'd2, 32'h8000_0000);
    check("R7 flag cleared", {31'b0, mabort}, 32'h0);

    acc("R8 ctrl all", 1'b1, 8'h08, 2'd2, 32'h7FFF_FFFF);
    check("R8 cmd", {29'b0, cmd}, 32'h7);
    rd_lit("R8 ctrl read", 8'h08, 32'h0000_0007);
    acc("R8 ctrl lane0", 1'b1, 8'h08, 2'd0, 32'h0000_0002);
    check("R8 cmd mem only", {29'b0, cmd}, 32'h2);

    acc("R9 io write", 1'b1, 8'h00, 2'd2, 32'hFFFF_FFFF);
    rd_lit("R9 io mask", 8'h00, 32'hFFFF_0000);
    acc("R9 io byte", 1'b1, 8'h02, 2'd0, 32'h0035_0000);
    rd_lit("R9 io lane2", 8'h00, 32'hFF35_0000);

    acc("R12 unmapped write", 1'b1, 8'h10, 2'd2, 32'hFFFF_FFFF);
    rd_lit("R12 unmapped read", 8'h10, 32'h0);
    rd_lit("R12 past window", 8'h30, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule